// File: doc/BRIEF.md
# Addressing-Mode Control Step Sequencer

This block is the hardwired control unit of a processor built around one internal bus. Each clock it issues the register-transfer strobes for one control step. Every instruction starts with a three-step fetch that is the same for all modes. In the fetch, the program counter goes out to the memory address register, its incremented copy returns to the program counter, and the fetched word moves through the memory data register into the instruction register.

After the fetch, the operand phase depends on the addressing-mode field decoded from the instruction register. Immediate mode puts the instruction's operand field straight onto the bus. Direct mode makes one memory access at the address held in the instruction. Indirect mode makes two accesses: the first returns the operand's address and the second returns the operand. Steps that wait on memory stall until the ready handshake is high.

The last step loads the destination register chosen by the destination field and raises an end strobe. The next step is then the first fetch step of the next instruction.

Top module: `ctrl_seq_top`

## Requirements
- R1: While reset is low and in the first step after it, the block drives pc_out, mar_in, mem_rd, alu_add_c and tmp_ld high and every other strobe low. Reset is asynchronous and active low.
- R2: Steps 1 to 3 produce the same strobes for every value of the mode field.
- R3: Step 2 stalls while mem_rdy_i is low and then drives no strobe at all. In the cycle mem_rdy_i is high, it drives pc_in and mdr_in.
- R4: Step 3 drives mdr_out and ir_in.
- R5: In immediate mode (mode field 00), the instruction has 4 steps. Step 4 drives ir_addr_out, one dst_we_o bit and end_o.
- R6: In direct mode (mode field 01), the instruction has 6 steps. Step 4 drives ir_addr_out, mar_in and mem_rd. Step 5 waits for ready, then drives mdr_in. Step 6 drives mdr_out, dst_we_o and end_o.
- R7: In indirect mode (mode field 10), the instruction has 7 steps.
  - Steps 4 and 5 are the same as in direct mode.
  - Step 6 drives mdr_out, mar_in and mem_rd.
  - Step 7 waits for ready, then drives mdr_in, mdr_out, dst_we_o and end_o together.
- R8: Mode field 11 produces exactly the immediate-mode sequence.
- R9: In any waiting step (2, 5, 7) with mem_rdy_i low, the step does not advance and all strobes are low.
- R10: The cycle after end_o is high is step 1.
- R11: dst_we_o is zero except in the end step. In the end step it has exactly one bit set, at index dst_sel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Addressing-mode field from the instruction register |
| dst_sel_i | input | DST_W | Destination-register index from the instruction register |
| mem_rdy_i | input | 1 | Memory word ready |
| pc_out_o | output | 1 | Program counter drives the bus |
| pc_in_o | output | 1 | Program counter loads from the temporary register |
| mar_in_o | output | 1 | Memory address register loads from the bus |
| mdr_in_o | output | 1 | Memory data register loads from memory |
| mdr_out_o | output | 1 | Memory data register drives the bus |
| ir_in_o | output | 1 | Instruction register loads from the bus |
| ir_addr_out_o | output | 1 | Instruction address/operand field drives the bus |
| alu_add_c_o | output | 1 | ALU adds the fixed increment to the bus value |
| tmp_ld_o | output | 1 | Temporary register loads the ALU result |
| mem_rd_o | output | 1 | Memory read request |
| dst_we_o | output | NUM_DST | One-hot destination-register load |
| end_o | output | 1 | Last step of the instruction |

## Verification
The checker assumes that the mode and destination fields stay unchanged from step 4 to the end of the instruction, because they come from an instruction register that has already been loaded. The stimulus changes these fields only in the first fetch step of each instruction. It toggles the ready input freely in every step, including steps that do not wait, where ready must have no effect. One run also asserts reset in the middle of an indirect operand phase.

// File: rtl/ctrl_seq_pkg.sv
package ctrl_seq_pkg;
  localparam int unsigned MAX_STEPS = 7;
  localparam int unsigned STEP_W    = $clog2(MAX_STEPS);

  typedef logic [STEP_W-1:0] step_t;

  localparam step_t S1 = step_t'(0);
  localparam step_t S2 = step_t'(1);
  localparam step_t S3 = step_t'(2);
  localparam step_t S4 = step_t'(3);
  localparam step_t S5 = step_t'(4);
  localparam step_t S6 = step_t'(5);
  localparam step_t S7 = step_t'(6);

  typedef enum logic [1:0] {
    MODE_IMM = 2'b00,
    MODE_DIR = 2'b01,
    MODE_IND = 2'b10,
    MODE_RSV = 2'b11
  } addr_mode_e;

  typedef struct packed {
    logic pc_out;
    logic pc_in;
    logic mar_in;
    logic mdr_in;
    logic mdr_out;
    logic ir_in;
    logic ir_addr_out;
    logic alu_add_c;
    logic tmp_ld;
    logic mem_rd;
    logic dst_ld;
    logic end_instr;
  } ctrl_word_t;
endpackage

// File: rtl/ctrl_step_cnt.sv
module ctrl_step_cnt
  import ctrl_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  end_i,
  input  logic  hold_i,
  output step_t step_o
);
  step_t step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   step_q <= S1;
    else if (end_i)                step_q <= S1;
    else if (hold_i)               step_q <= step_q;
    else if (step_q == S7)         step_q <= S1;
    else                           step_q <= step_q + 1'b1;
  end

  assign step_o = step_q;
endmodule

// File: rtl/ctrl_step_decode.sv
module ctrl_step_decode
  import ctrl_seq_pkg::*;
(
  input  step_t      step_i,
  input  addr_mode_e mode_i,
  input  logic       rdy_i,
  output ctrl_word_t cw_o,
  output logic       hold_o
);
  addr_mode_e eff_mode;

  // reserved code falls back to immediate
  assign eff_mode = (mode_i == MODE_RSV) ? MODE_IMM : mode_i;

  always_comb begin
    cw_o   = '0;
    hold_o = 1'b0;
    case (step_i)
      S1: begin
        cw_o.pc_out    = 1'b1;
        cw_o.mar_in    = 1'b1;
        cw_o.mem_rd    = 1'b1;
        cw_o.alu_add_c = 1'b1;
        cw_o.tmp_ld    = 1'b1;
      end
      S2: begin
        if (rdy_i) begin
          cw_o.pc_in  = 1'b1;
          cw_o.mdr_in = 1'b1;
        end else begin
          hold_o = 1'b1;
        end
      end
      S3: begin
        cw_o.mdr_out = 1'b1;
        cw_o.ir_in   = 1'b1;
      end
      S4: begin
        cw_o.ir_addr_out = 1'b1;
        if (eff_mode == MODE_IMM) begin
          cw_o.dst_ld    = 1'b1;
          cw_o.end_instr = 1'b1;
        end else begin
          cw_o.mar_in = 1'b1;
          cw_o.mem_rd = 1'b1;
        end
      end
      S5: begin
        if (rdy_i) cw_o.mdr_in = 1'b1;
        else       hold_o      = 1'b1;
      end
      S6: begin
        cw_o.mdr_out = 1'b1;
        if (eff_mode == MODE_IND) begin
          cw_o.mar_in = 1'b1;
          cw_o.mem_rd = 1'b1;
        end else begin
          cw_o.dst_ld    = 1'b1;
          cw_o.end_instr = 1'b1;
        end
      end
      S7: begin
        if (rdy_i) begin
          // memory word flows through the data register to the destination
          cw_o.mdr_in    = 1'b1;
          cw_o.mdr_out   = 1'b1;
          cw_o.dst_ld    = 1'b1;
          cw_o.end_instr = 1'b1;
        end else begin
          hold_o = 1'b1;
        end
      end
      default: cw_o.end_instr = 1'b1;
    endcase
  end
endmodule

// File: rtl/ctrl_dst_dec.sv
module ctrl_dst_dec #(
  parameter int unsigned NUM_DST = 4,
  parameter int unsigned DST_W   = (NUM_DST > 1) ? $clog2(NUM_DST) : 1
) (
  input  logic [DST_W-1:0]   sel_i,
  input  logic               en_i,
  output logic [NUM_DST-1:0] we_o
);
  for (genvar g = 0; g < NUM_DST; g++) begin : g_we
    assign we_o[g] = en_i && (sel_i == DST_W'(g));
  end
endmodule

// File: rtl/ctrl_seq_top.sv
module ctrl_seq_top
  import ctrl_seq_pkg::*;
#(
  parameter  int unsigned NUM_DST = 4,
  localparam int unsigned DST_W   = (NUM_DST > 1) ? $clog2(NUM_DST) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic [DST_W-1:0]   dst_sel_i,
  input  logic               mem_rdy_i,
  output logic               pc_out_o,
  output logic               pc_in_o,
  output logic               mar_in_o,
  output logic               mdr_in_o,
  output logic               mdr_out_o,
  output logic               ir_in_o,
  output logic               ir_addr_out_o,
  output logic               alu_add_c_o,
  output logic               tmp_ld_o,
  output logic               mem_rd_o,
  output logic [NUM_DST-1:0] dst_we_o,
  output logic               end_o
);
  step_t      step_q;
  ctrl_word_t cw;
  logic       hold;

  ctrl_step_cnt i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .end_i  (cw.end_instr),
    .hold_i (hold),
    .step_o (step_q)
  );

  ctrl_step_decode i_dec (
    .step_i (step_q),
    .mode_i (addr_mode_e'(mode_i)),
    .rdy_i  (mem_rdy_i),
    .cw_o   (cw),
    .hold_o (hold)
  );

  ctrl_dst_dec #(.NUM_DST(NUM_DST), .DST_W(DST_W)) i_dst (
    .sel_i (dst_sel_i),
    .en_i  (cw.dst_ld),
    .we_o  (dst_we_o)
  );

  assign pc_out_o      = cw.pc_out;
  assign pc_in_o       = cw.pc_in;
  assign mar_in_o      = cw.mar_in;
  assign mdr_in_o      = cw.mdr_in;
  assign mdr_out_o     = cw.mdr_out;
  assign ir_in_o       = cw.ir_in;
  assign ir_addr_out_o = cw.ir_addr_out;
  assign alu_add_c_o   = cw.alu_add_c;
  assign tmp_ld_o      = cw.tmp_ld;
  assign mem_rd_o      = cw.mem_rd;
  assign end_o         = cw.end_instr;
endmodule

// File: rtl/ctrl_seq_chk.sv
module ctrl_seq_chk
  import ctrl_seq_pkg::*;
#(
  parameter int unsigned NUM_DST = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         mode_i,
  input logic               mem_rdy_i,
  input step_t              step_i,
  input ctrl_word_t         cw_i,
  input logic [NUM_DST-1:0] dst_we_i
);
  logic waiting, any_load;
  assign waiting  = (step_i == S2 || step_i == S5 || step_i == S7) && !mem_rdy_i;
  assign any_load = cw_i.pc_in | cw_i.mar_in | cw_i.mdr_in | cw_i.ir_in |
                    cw_i.tmp_ld | (|dst_we_i) | cw_i.mem_rd | cw_i.end_instr;

  // input assumption: fields steady during the operand phase
  mode_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i >= S5) |-> $stable(mode_i));

  // R1
  fetch_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_i.pc_out |-> (cw_i.mar_in && cw_i.mem_rd && cw_i.alu_add_c && cw_i.tmp_ld));

  // R4
  ir_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_i.ir_in |-> (cw_i.mdr_out && step_i == S3));

  // R9
  stall_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting |-> !any_load);

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting |=> $stable(step_i));

  // R10
  end_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_i.end_instr |=> (step_i == S1));

  // R11
  dst_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dst_we_i) && ((|dst_we_i) == cw_i.end_instr));

  // R7
  ind_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == S7) |-> (mode_i == 2'b10));

  // R8
  rsv_imm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == S4 && mode_i == 2'b11) |-> cw_i.end_instr);
endmodule

bind ctrl_seq_top ctrl_seq_chk #(.NUM_DST(NUM_DST)) i_ctrl_seq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .mem_rdy_i (mem_rdy_i),
  .step_i    (step_q),
  .cw_i      (cw),
  .dst_we_i  (dst_we_o)
);

// File: tb/test_ctrl_seq_top.sv
`timescale 1ns/1ps
module test_ctrl_seq_top;
  localparam int NUM_DST = 4;
  localparam int DST_W   = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst_ni;
  logic [1:0]         mode;
  logic [DST_W-1:0]   dst_sel;
  logic               rdy;
  logic               pc_out, pc_in, mar_in, mdr_in, mdr_out, ir_in, ir_addr_out;
  logic               alu_add, tmp_ld, mem_rd, end_s;
  logic [NUM_DST-1:0] dst_we;

  ctrl_seq_top #(.NUM_DST(NUM_DST)) i_ctrl_seq_top (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .dst_sel_i(dst_sel), .mem_rdy_i(rdy),
    .pc_out_o(pc_out), .pc_in_o(pc_in), .mar_in_o(mar_in), .mdr_in_o(mdr_in),
    .mdr_out_o(mdr_out), .ir_in_o(ir_in), .ir_addr_out_o(ir_addr_out),
    .alu_add_c_o(alu_add), .tmp_ld_o(tmp_ld), .mem_rd_o(mem_rd),
    .dst_we_o(dst_we), .end_o(end_s)
  );

  int n_chk = 0;
  int n_bad = 0;
  int pos   = 0;   // model step index, 0 = step 1
  bit done  = 0;

  // bit order: pc_out pc_in mar_in mdr_in mdr_out ir_in ir_addr_out alu_add tmp_ld mem_rd end
  function automatic logic [10:0] exp_word(int m, int p, logic r);
    int mm = (m == 3) ? 0 : m;
    case (p)
      0: return 11'b1010000_1110;
      1: return r ? 11'b0101000_0000 : 11'b0;
      2: return 11'b0000110_0000;
      3: return (mm == 0) ? 11'b0000001_0001 : 11'b0010001_0010;
      4: return r ? 11'b0001000_0000 : 11'b0;
      5: return (mm == 2) ? 11'b0010100_0010 : 11'b0000100_0001;
      6: return r ? 11'b0001100_0001 : 11'b0;
      default: return 11'b0;
    endcase
  endfunction

  function automatic string tag(int m, int p);
    if (p == 0) return "R1/R2";
    if (p == 1) return "R3/R9";
    if (p == 2) return "R4";
    if (m == 3) return "R8";
    if (m == 0) return "R5/R10";
    if (m == 1) return "R6/R10";
    return "R7/R9";
  endfunction

  function automatic logic [10:0] act_word();
    return {pc_out, pc_in, mar_in, mdr_in, mdr_out, ir_in, ir_addr_out,
            alu_add, tmp_ld, mem_rd, end_s};
  endfunction

  // compare current outputs; returns 1 if this step ends the instruction
  task automatic check_now(output bit ended);
    logic [10:0]        e  = exp_word(int'(mode), pos, rdy);
    logic [NUM_DST-1:0] ed = e[0] ? (NUM_DST'(1) << dst_sel) : '0;
    n_chk++;
    if (act_word() !== e) begin
      n_bad++;
      $display("FAIL %s step %0d mode %0d: strobes %b expected %b",
               tag(int'(mode), pos), pos + 1, mode, act_word(), e);
    end
    n_chk++;
    if (dst_we !== ed) begin
      n_bad++;
      $display("FAIL R11 step %0d: dst_we %b expected %b", pos + 1, dst_we, ed);
    end
    ended = e[0];
    if (e[0]) pos = 0;
    else if ((pos == 1 || pos == 4 || pos == 6) && !rdy) pos = pos;
    else pos = pos + 1;
  endtask

  // run one instruction; rdy_mode 0: always ready, 1: random ready
  task automatic run_instr(int m, int d, int rdy_mode);
    bit ended = 0;
    int guard = 0;
    while (!ended && guard < 200) begin
      @(negedge clk);
      if (pos == 0) begin
        mode    = m[1:0];
        dst_sel = d[DST_W-1:0];
      end
      rdy = (rdy_mode == 0) ? 1'b1 : ($urandom_range(0, 2) == 0);
      #1;
      check_now(ended);
      guard++;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at step %0d", pos + 1);
      summary();
      $finish;
    end
  end

  initial begin
    bit dummy;
    rst_ni = 1'b0; mode = 2'b10; dst_sel = '0; rdy = 1'b0;
    // R1 reset state, held over clock edges
    repeat (2) begin
      @(negedge clk); #1;
      pos = 0;
      n_chk++;
      if (act_word() !== exp_word(0, 0, 1'b0) || dst_we !== '0) begin
        n_bad++;
        $display("FAIL R1 reset: strobes %b expected %b", act_word(), exp_word(0, 0, 1'b0));
      end
    end
    @(negedge clk); rst_ni = 1'b1;
    pos = 0;
    #1; check_now(dummy);   // R1 first step after reset

    // each mode with no waits: R5 R6 R7 R8
    run_instr(0, 1, 0);
    run_instr(1, 2, 0);
    run_instr(2, 3, 0);
    run_instr(3, 0, 0);
    // random ready, stalls: R3 R9
    for (int i = 0; i < 40; i++) run_instr(i % 4, (i * 3) % NUM_DST, 1);

    // mid-instruction reset in indirect operand phase: R1
    while (pos != 4) begin
      @(negedge clk);
      if (pos == 0) begin mode = 2'b10; dst_sel = 2'd2; end
      rdy = 1'b1;
      if (pos == 3) rdy = 1'b1;
      #1; check_now(dummy);
    end
    @(negedge clk); rst_ni = 1'b0; rdy = 1'b0; #1;
    pos = 0;
    n_chk++;
    if (act_word() !== exp_word(0, 0, 1'b0)) begin
      n_bad++;
      $display("FAIL R1 async reset: strobes %b expected %b", act_word(), exp_word(0, 0, 1'b0));
    end
    @(negedge clk); rst_ni = 1'b1;
    pos = 0;
    #1; check_now(dummy);
    run_instr(1, 1, 0);

    for (int i = 0; i < 200; i++) run_instr(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule